// File: doc/BRIEF.md
# Serial DAC Write Controller

This block sends one 12-bit sample to a single-channel serial digital-to-analog converter that has its own voltage reference. A one-cycle start request, given while the block is free, launches one transaction. The block first checks the enable control. If enable is low, it drops the request and goes back to waiting. If enable is high, it builds a 16-bit command word from three parts: the sample, a gain choice (1x or 2x) and a power-down choice. It shifts this word out, most significant bit first, over a three-wire serial link made of chip select, serial clock and serial data. It then gives the converter an active-low load strobe so the analog output takes the new value. Last, it holds off further requests for a fixed idle gap.

The controller is a seven-state machine:

- WAIT: ready for a request.
- QUALIFY: checks enable.
- ARM: the data driver turns on with the first bit.
- SHIFT: 16 serial-clock periods with chip select low.
- LOAD_ON: the strobe is low for a set number of cycles.
- LOAD_OFF: the strobe is released.
- IDLE: the gap timer runs.

The transitions are:

- WAIT→QUALIFY when start is high.
- QUALIFY→ARM when enable is high; QUALIFY→WAIT when enable is low.
- ARM→SHIFT always.
- SHIFT→LOAD_ON after the 16th bit.
- LOAD_ON→LOAD_OFF when the hold count expires.
- LOAD_OFF→IDLE always.
- IDLE→WAIT when the gap count expires.

The serial clock runs at a quarter of the system clock, which gives 10 MHz from a 40 MHz clock. The sample, gain and power-down inputs are captured when QUALIFY is left.

Top module: `dac_write_ctrl`

## Requirements
- R1: While reset is held and right after it, cs_n_o=1, sclk_o=0, sdo_o=0, load_n_o=1 and busy_o=0.
- R2: A start_i pulse seen in WAIT sets busy_o from the next cycle. busy_o stays high for exactly 2+16*SCLK_DIV+LOAD_HOLD+1+IDLE_GAP cycles, which is 79 with the defaults.
- R3: If enable_i is low when QUALIFY is evaluated, no frame is sent, the strobe does not pulse, and busy_o is high for exactly one cycle.
- R4: The word is sent MSB first. Bits 15 and 14 are 0. Bit 13 is the inverse of gain2x_i (1 selects 1x gain, 0 selects 2x gain). Bit 12 is the inverse of shutdown_i (1 means the output is active). Bits 11..0 are sample_i.
- R5: sclk_o idles low, is low whenever cs_n_o is high, and each of its periods is SCLK_DIV system cycles, high for the second half. Each frame has exactly 16 rising edges, and cs_n_o is low for exactly 16*SCLK_DIV cycles.
- R6: sdo_o does not change in any cycle in which cs_n_o is low and sclk_o is high. Data is therefore launched on the falling edge and stable on the rising edge.
- R7: After each frame, load_n_o goes low for exactly LOAD_HOLD cycles, and only while cs_n_o is high.
- R8: A start_i pulse while busy_o is high is ignored. No extra frame follows, and busy_o timing is unchanged.
- R9: A request made in the first cycle after busy_o falls is accepted and produces a full, correct frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transaction request, sampled in WAIT |
| sample_i | input | 12 | Sample value to convert |
| enable_i | input | 1 | Transaction is dropped when low |
| gain2x_i | input | 1 | 1 selects 2x output gain, 0 selects 1x |
| shutdown_i | input | 1 | 1 powers the converter output down |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data toward the converter |
| load_n_o | output | 1 | Active-low load strobe |
| busy_o | output | 1 | High from request acceptance to return to WAIT |

## Verification
The assertions assume that start_i, enable_i and the data inputs change only between clock edges, and that the data inputs hold steady from the request until QUALIFY has been left. The bench drives every input on the falling clock edge. It keeps sample_i, gain2x_i, shutdown_i and enable_i fixed from the start pulse until busy_o drops. Nothing the checker observes depends on start_i arriving during a transaction, so the bench sends extra requests mid-frame to exercise the ignore rule without breaking these assumptions.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    localparam int SAMPLE_W = 12;
    localparam int CMD_W    = 16;

    typedef enum logic [2:0] {
        ST_WAIT     = 3'd0,
        ST_QUALIFY  = 3'd1,
        ST_ARM      = 3'd2,
        ST_SHIFT    = 3'd3,
        ST_LOAD_ON  = 3'd4,
        ST_LOAD_OFF = 3'd5,
        ST_IDLE     = 3'd6
    } seq_state_e;

    // Command layout: [15] write=0, [14] unused=0, [13] gain (low = 2x),
    // [12] active (low = powered down), [11:0] sample
    function automatic logic [CMD_W-1:0] pack_cmd(
        input logic [SAMPLE_W-1:0] smp,
        input logic                gain2x,
        input logic                pwr_down
    );
        return {1'b0, 1'b0, ~gain2x, ~pwr_down, smp};
    endfunction

endpackage

// File: rtl/dac_sclk_gen.sv
module dac_sclk_gen #(
    parameter int SCLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic period_end
);
    localparam int PH_W = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SCLK_DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(SCLK_DIV / 2);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || phase_q == PH_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign sclk       = run && (phase_q >= PH_HALF);
    assign period_end = run && (phase_q == PH_LAST);

endmodule

// File: rtl/dac_shifter.sv
module dac_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              step,
    input  logic              drive,
    output logic              sdo,
    output logic              last_bit
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sreg_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            sreg_q <= word;
            cnt_q  <= '0;
        end else if (step) begin
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign sdo      = drive && sreg_q[WORD_W-1];
    assign last_bit = step && (cnt_q == CNT_LAST);

endmodule

// File: rtl/dac_cycle_timer.sv
module dac_cycle_timer #(
    parameter int MAX_COUNT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic [$clog2(MAX_COUNT+1)-1:0] len,
    output logic expired
);
    localparam int TW = $clog2(MAX_COUNT + 1);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (arm) begin
            left_q <= len - 1'b1;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign expired = (left_q == '0);

endmodule

// File: rtl/dac_write_ctrl.sv
module dac_write_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int SCLK_DIV  = 4,
    parameter int LOAD_HOLD = 4,
    parameter int IDLE_GAP  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                enable_i,
    input  logic                gain2x_i,
    input  logic                shutdown_i,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic                sdo_o,
    output logic                load_n_o,
    output logic                busy_o
);
    localparam int TMAX = (LOAD_HOLD > IDLE_GAP) ? LOAD_HOLD : IDLE_GAP;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] HOLD_LEN = TW'(LOAD_HOLD);
    localparam logic [TW-1:0] GAP_LEN  = TW'(IDLE_GAP);

    seq_state_e state_q, state_d;

    logic sclk_run, sclk_int, period_end;
    logic sh_load, sh_drive, sdo_int, last_bit;
    logic tmr_arm, tmr_expired;
    logic [TW-1:0] tmr_len;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:     if (start_i) state_d = ST_QUALIFY;
            ST_QUALIFY:  state_d = enable_i ? ST_ARM : ST_WAIT;
            ST_ARM:      state_d = ST_SHIFT;
            ST_SHIFT:    if (last_bit) state_d = ST_LOAD_ON;
            ST_LOAD_ON:  if (tmr_expired) state_d = ST_LOAD_OFF;
            ST_LOAD_OFF: state_d = ST_IDLE;
            ST_IDLE:     if (tmr_expired) state_d = ST_WAIT;
            default:     state_d = ST_WAIT;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        cs_n_o   = 1'b1;
        load_n_o = 1'b1;
        busy_o   = 1'b1;
        sclk_run = 1'b0;
        sh_drive = 1'b0;
        sh_load  = 1'b0;
        tmr_arm  = 1'b0;
        tmr_len  = HOLD_LEN;
        unique case (state_q)
            ST_WAIT:     busy_o = 1'b0;
            ST_QUALIFY:  sh_load = enable_i;
            ST_ARM:      sh_drive = 1'b1;
            ST_SHIFT: begin
                cs_n_o   = 1'b0;
                sclk_run = 1'b1;
                sh_drive = 1'b1;
                tmr_arm  = last_bit;
                tmr_len  = HOLD_LEN;
            end
            ST_LOAD_ON:  load_n_o = 1'b0;
            ST_LOAD_OFF: begin
                tmr_arm = 1'b1;
                tmr_len = GAP_LEN;
            end
            ST_IDLE:     ;
            default:     busy_o = 1'b0;
        endcase
    end

    assign sclk_o = sclk_int;
    assign sdo_o  = sdo_int;

    dac_sclk_gen #(.SCLK_DIV(SCLK_DIV)) u_sclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (sclk_run),
        .sclk       (sclk_int),
        .period_end (period_end)
    );

    dac_shifter #(.WORD_W(CMD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .word     (pack_cmd(sample_i, gain2x_i, shutdown_i)),
        .step     (period_end),
        .drive    (sh_drive),
        .sdo      (sdo_int),
        .last_bit (last_bit)
    );

    dac_cycle_timer #(.MAX_COUNT(TMAX)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (tmr_arm),
        .len     (tmr_len),
        .expired (tmr_expired)
    );

endmodule

// File: rtl/dac_write_ctrl_chk.sv
module dac_write_ctrl_chk #(
    parameter int LOAD_HOLD = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic sclk_o,
    input logic sdo_o,
    input logic load_n_o,
    input logic busy_o
);
    localparam int LW = $clog2(LOAD_HOLD + 2);
    logic [LW-1:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_run_q <= '0;
        else if (!load_n_o) low_run_q <= low_run_q + 1'b1;
        else               low_run_q <= '0;
    end

    AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);                                   // R5
    AST_SCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |=> sclk_o);                             // R5
    AST_SDO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && sclk_o) |-> $stable(sdo_o));               // R6
    AST_LOAD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_o |-> cs_n_o);                                 // R7
    AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q <= LW'(LOAD_HOLD));                          // R7
    AST_FRAME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o || !load_n_o) |-> busy_o);                    // R2
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && load_n_o && !sclk_o));          // R1

endmodule

bind dac_write_ctrl dac_write_ctrl_chk #(.LOAD_HOLD(LOAD_HOLD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .sdo_o    (sdo_o),
    .load_n_o (load_n_o),
    .busy_o   (busy_o)
);

// File: tb/test_dac_write_ctrl.sv
module test_dac_write_ctrl;

    localparam int DIV  = 4;
    localparam int HOLD = 4;
    localparam int GAP  = 8;
    localparam int BUSY_LEN = 2 + 16*DIV + HOLD + 1 + GAP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [11:0] sample_i = '0;
    logic enable_i = 1'b0, gain2x_i = 1'b0, shutdown_i = 1'b0;
    logic cs_n_o, sclk_o, sdo_o, load_n_o, busy_o;

    int total = 0;
    int bad = 0;
    int frames = 0;
    logic [15:0] expq[$];

    always #2 clk = ~clk;

    dac_write_ctrl #(.SCLK_DIV(DIV), .LOAD_HOLD(HOLD), .IDLE_GAP(GAP)) i_dac_write_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_i(sample_i),
        .enable_i(enable_i), .gain2x_i(gain2x_i), .shutdown_i(shutdown_i),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdo_o(sdo_o),
        .load_n_o(load_n_o), .busy_o(busy_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: rebuilds frames and strobe widths, pops expected words
    initial begin
        logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_ld = 1'b1;
        logic [15:0] got = '0;
        int edges = 0, cs_cnt = 0, ld_cnt = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!cs_n_o) cs_cnt++;
                if (sclk_o && !prev_sclk) begin
                    got = {got[14:0], sdo_o};
                    edges++;
                end
                if (!load_n_o) begin
                    ld_cnt++;
                    check("R7 strobe with cs high", cs_n_o, 1);
                end
                if (cs_n_o && !prev_cs) begin
                    frames++;
                    check("R5 sclk rising edges", edges, 16);
                    check("R5 cs low cycles", cs_cnt, 16*DIV);
                    if (expq.size() == 0) begin
                        check("R8 unexpected frame", 1, 0);
                    end else begin
                        check("R4 command word", got, expq.pop_front());
                    end
                    edges = 0;
                    cs_cnt = 0;
                end
                if (load_n_o && !prev_ld) begin
                    check("R7 strobe width", ld_cnt, HOLD);
                    ld_cnt = 0;
                end
                prev_cs = cs_n_o;
                prev_sclk = sclk_o;
                prev_ld = load_n_o;
            end
        end
    end

    // driver: issues one request and measures busy length
    task automatic request(input logic [11:0] s, input logic g, input logic sd,
                           input logic en, input bit poke, input string req);
        int n = 1;
        sample_i = s; gain2x_i = g; shutdown_i = sd; enable_i = en;
        start_i = 1'b1;
        if (en) expq.push_back({2'b00, ~g, ~sd, s});
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) begin
            @(negedge clk);
            if (poke && n == 20) start_i = 1'b1;   // R8 mid-frame request
            else start_i = 1'b0;
            n++;
        end
        start_i = 1'b0;
        check(req, n - 1, en ? BUSY_LEN : 1);
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cs_n in reset", cs_n_o, 1);
        check("R1 sclk in reset", sclk_o, 0);
        check("R1 sdo in reset", sdo_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 load_n after reset", load_n_o, 1);
        check("R1 busy after reset", busy_o, 0);

        request(12'h000, 1'b0, 1'b0, 1'b1, 1'b0, "R2 busy length 1x active");
        request(12'hFFF, 1'b1, 1'b0, 1'b1, 1'b0, "R2 busy length 2x");
        request(12'hA5A, 1'b0, 1'b1, 1'b1, 1'b0, "R2 busy length shutdown");
        request(12'h3C7, 1'b1, 1'b1, 1'b1, 1'b0, "R2 busy length both");
        request(12'h555, 1'b0, 1'b0, 1'b0, 1'b0, "R3 disabled busy one cycle");
        repeat (10) @(negedge clk);
        check("R3 no frame when disabled", frames, 4);
        check("R3 strobe idle", load_n_o, 1);
        request(12'h801, 1'b0, 1'b0, 1'b1, 1'b1, "R8 busy unchanged by extra start");
        request(12'h1E3, 1'b1, 1'b0, 1'b1, 1'b0, "R9 back-to-back request");
        repeat (BUSY_LEN + 5) @(negedge clk);
        check("R8 frame count", frames, 6);
        check("R8 nothing pending", expq.size(), 0);
        check("R8 idle after extra start", busy_o, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule